// File: doc/BRIEF.md
# One-wire device ID search engine

This block finds every 64-bit device identifier present on a single-wire bus. A start pulse begins an enumeration made of search passes. Each pass first asks a transaction layer to issue the search command (bus reset plus command byte). It then walks the 64 identifier bit positions. At each position it performs two read slots, the true bit and then its complement, and one write slot carrying the chosen direction. The devices use this direction to drop out of the pass, so each pass isolates exactly one identifier.

Between passes the engine keeps the previous identifier and the position of the last conflict where it took direction 0. This lets the next pass branch the other way at that position. Each finished pass presents its identifier for one cycle with a CRC-ok flag and the family byte. The enumeration ends with a done pulse once a pass leaves no open branch. It ends with an error pulse when:

- the command transaction fails,
- the bus stops answering too many times in a row, or
- the pass budget runs out.

Top module: `owid_search`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `cmd_req_o`, `slot_req_o`, `id_valid_o`, `done_o` and `err_o` are 0. A `start_i` pulse while idle raises `busy_o` and `cmd_req_o`. Every pass, including a restarted one, completes one command transaction before its first slot.
- R2: A pass performs, for bit positions 0 to 63 in turn, a read slot (`slot_write_o`=0) for the true bit, a read slot for the complement, and a write slot (`slot_write_o`=1) whose value `slot_wbit_o` is the direction. That gives 128 reads and 64 writes per pass. Bit i of the identifier is the direction written at position i (least significant bit first).
- R3: A read pair of true=1, complement=0 writes direction 1. A pair of true=0, complement=1 writes direction 0.
- R4: A pair of 0,0 is a conflict. Below the previous pass's last zero-conflict position, the direction is the previous identifier's bit. At that position it is 1. Above it, or when no previous position exists (first pass), it is 0. The last conflict resolved with 0 becomes the pass's new branch position.
- R5: A pair of 1,1 (no response) abandons the pass and restarts it with a new command, keeping the previous branch state. A sixth consecutive no-response (more than MAX_RETRY=5) ends the enumeration with `err_o` and no identifier.
- R6: The consecutive no-response count clears when a pass completes. Five no-responses in every pass therefore never cause an error.
- R7: Each completed pass raises `id_valid_o` for exactly one cycle, with `id_value_o` holding the identifier and `id_family_o` equal to its lowest byte. Identifiers come out in ascending order of their bit-reversed value.
- R8: `id_crc_ok_o` is 1 exactly when the CRC-8 over the eight identifier bytes, lowest byte first, gives 0. The CRC is reflected, with polynomial x^8+x^5+x^4+1 (shift value 0x8C) and initial value 0.
- R9: When a pass records no zero-conflict, `done_o` pulses for one cycle in the cycle after its `id_valid_o`, and `busy_o` is 0 in that cycle. `done_o` and `err_o` are never high together.
- R10: If the MAX_PASS-th (11th) completed pass still leaves an open branch, `err_o` pulses in the cycle after that pass's identifier, instead of a new pass starting. With 11 devices the enumeration ends with `done_o`; with 12 it ends with `err_o` after 11 identifiers.
- R11: A command transaction ending with `cmd_ok_i`=0 ends the enumeration with `err_o` in the next cycle, with no slot issued.
- R12: `start_i` is ignored while `busy_o` is 1. The identifier sequence and the single outcome pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an enumeration (accepted when idle) |
| busy_o | output | 1 | Enumeration in progress |
| cmd_req_o | output | 1 | Request: reset bus and send the search command |
| cmd_done_i | input | 1 | Command transaction finished (one-cycle pulse) |
| cmd_ok_i | input | 1 | Command transaction saw a device presence |
| slot_req_o | output | 1 | Request one bit slot |
| slot_write_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit_o | output | 1 | Value for a write slot |
| slot_done_i | input | 1 | Bit slot finished (one-cycle pulse) |
| slot_rbit_i | input | 1 | Bus level sampled in a read slot, valid with slot_done_i |
| id_valid_o | output | 1 | Identifier of a completed pass is presented |
| id_value_o | output | ID_BITS | Identifier, bit 0 first on the bus |
| id_family_o | output | 8 | Lowest identifier byte |
| id_crc_ok_o | output | 1 | CRC-8 of the identifier checks out |
| done_o | output | 1 | Enumeration finished normally (pulse) |
| err_o | output | 1 | Enumeration aborted (pulse) |

## Verification
The hardest states to reach are the retry and pass budgets. A real bus rarely returns the all-ones pair, and tripping the pass limit needs a crowded bus whose branches keep one open. The bench models the devices as a wired-AND population of up to twelve identifiers. It can force the all-ones pair at a chosen bit position a chosen number of times per pass. It runs five forced restarts in every pass, then six in one pass, and populations of eleven and twelve devices, to land on both sides of each limit.

// File: rtl/owid_pkg.sv
package owid_pkg;

  localparam logic [7:0] OWID_CRC_POLY = 8'h8C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_RD_T,
    ST_RD_C,
    ST_WR,
    ST_EMIT
  } owid_state_e;

  typedef struct packed {
    logic none;
    logic conflict;
    logic dir;
  } owid_pick_t;

  // one bit of the reflected CRC-8
  function automatic logic [7:0] owid_crc_step(input logic [7:0] crc, input logic din);
    logic fb;
    fb = crc[0] ^ din;
    return {1'b0, crc[7:1]} ^ (fb ? OWID_CRC_POLY : 8'h00);
  endfunction

  // direction choice from the read pair and the branch history
  function automatic owid_pick_t owid_pick(input logic t, input logic c, input logic prior_vld,
                                           input logic below, input logic at, input logic prev_bit);
    owid_pick_t p;
    p = '0;
    unique case ({t, c})
      2'b11: p.none = 1'b1;
      2'b10: p.dir  = 1'b1;
      2'b01: p.dir  = 1'b0;
      default: begin
        p.conflict = 1'b1;
        if (!prior_vld)  p.dir = 1'b0;
        else if (below)  p.dir = prev_bit;
        else             p.dir = at;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/owid_branch.sv
module owid_branch
  import owid_pkg::*;
#(
  parameter int ID_BITS = 64,
  localparam int IDX_W = $clog2(ID_BITS)
) (
  input  logic               rd_t_i,
  input  logic               rd_c_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               prior_vld_i,
  input  logic [IDX_W-1:0]   prior_idx_i,
  input  logic [ID_BITS-1:0] prev_id_i,
  output owid_pick_t         pick_o
);

  logic below_prior;
  logic at_prior;

  assign below_prior = idx_i < prior_idx_i;
  assign at_prior    = idx_i == prior_idx_i;
  assign pick_o      = owid_pick(rd_t_i, rd_c_i, prior_vld_i, below_prior, at_prior,
                                 prev_id_i[idx_i]);

endmodule

// File: rtl/owid_crc_ser.sv
module owid_crc_ser
  import owid_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic din_i,
  output logic zero_o
);

  logic [7:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= owid_crc_step(crc_q, din_i);
  end

  assign zero_o = crc_q == 8'h00;

endmodule

// File: rtl/owid_limits.sv
module owid_limits #(
  parameter int MAX_RETRY = 5,
  parameter int MAX_PASS  = 11,
  localparam int RW = $clog2(MAX_RETRY + 1),
  localparam int PW = $clog2(MAX_PASS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic retry_i,
  input  logic pass_end_i,
  output logic retry_over_o,
  output logic pass_full_o
);

  logic [RW-1:0] retry_cnt;
  logic [PW-1:0] pass_cnt;

  assign retry_over_o = retry_cnt == RW'(MAX_RETRY);
  assign pass_full_o  = pass_cnt == PW'(MAX_PASS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_cnt <= '0;
      pass_cnt  <= '0;
    end else begin
      if (clr_i || pass_end_i)              retry_cnt <= '0;
      else if (retry_i && !retry_over_o)    retry_cnt <= retry_cnt + 1'b1;
      if (clr_i)                            pass_cnt <= '0;
      else if (pass_end_i && pass_cnt != PW'(MAX_PASS)) pass_cnt <= pass_cnt + 1'b1;
    end
  end

  assert_retry_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= RW'(MAX_RETRY));

  assert_retry_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end_i && !clr_i) |=> retry_cnt == '0);

  assert_pass_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pass_cnt <= PW'(MAX_PASS));

endmodule

// File: rtl/owid_search.sv
module owid_search
  import owid_pkg::*;
#(
  parameter int ID_BITS   = 64,
  parameter int MAX_RETRY = 5,
  parameter int MAX_PASS  = 11,
  localparam int IDX_W = $clog2(ID_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               busy_o,
  output logic               cmd_req_o,
  input  logic               cmd_done_i,
  input  logic               cmd_ok_i,
  output logic               slot_req_o,
  output logic               slot_write_o,
  output logic               slot_wbit_o,
  input  logic               slot_done_i,
  input  logic               slot_rbit_i,
  output logic               id_valid_o,
  output logic [ID_BITS-1:0] id_value_o,
  output logic [7:0]         id_family_o,
  output logic               id_crc_ok_o,
  output logic               done_o,
  output logic               err_o
);

  owid_state_e        st;
  logic [IDX_W-1:0]   bit_idx;
  logic               rd_t;
  logic               dir_q;
  logic [ID_BITS-1:0] cur_id;
  logic [ID_BITS-1:0] prev_id;
  logic [IDX_W-1:0]   last_idx;
  logic               last_vld;
  logic [IDX_W-1:0]   prior_idx;
  logic               prior_vld;

  owid_pick_t pick;
  logic       retry_over;
  logic       pass_full;
  logic       crc_zero;

  // named internal events
  logic ev_start;
  logic ev_decide;
  logic ev_noresp;
  logic ev_wr_done;
  logic ev_last_bit;
  logic ev_pass_end;
  logic ev_begin;

  assign ev_start    = (st == ST_IDLE) && start_i;
  assign ev_decide   = (st == ST_RD_C) && slot_done_i;
  assign ev_noresp   = ev_decide && pick.none;
  assign ev_wr_done  = (st == ST_WR) && slot_done_i;
  assign ev_last_bit = bit_idx == IDX_W'(ID_BITS - 1);
  assign ev_pass_end = st == ST_EMIT;
  assign ev_begin    = ev_start || (ev_noresp && !retry_over) ||
                       (ev_pass_end && last_vld && !pass_full);

  owid_branch #(.ID_BITS(ID_BITS)) u_branch (
    .rd_t_i      (rd_t),
    .rd_c_i      (slot_rbit_i),
    .idx_i       (bit_idx),
    .prior_vld_i (prior_vld),
    .prior_idx_i (prior_idx),
    .prev_id_i   (prev_id),
    .pick_o      (pick)
  );

  owid_limits #(.MAX_RETRY(MAX_RETRY), .MAX_PASS(MAX_PASS)) u_limits (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (ev_start),
    .retry_i      (ev_noresp),
    .pass_end_i   (ev_pass_end),
    .retry_over_o (retry_over),
    .pass_full_o  (pass_full)
  );

  owid_crc_ser u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ev_begin),
    .en_i   (ev_wr_done),
    .din_i  (dir_q),
    .zero_o (crc_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_idx   <= '0;
      rd_t      <= 1'b0;
      dir_q     <= 1'b0;
      cur_id    <= '0;
      prev_id   <= '0;
      last_idx  <= '0;
      last_vld  <= 1'b0;
      prior_idx <= '0;
      prior_vld <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) prior_vld <= 1'b0;
        ST_CMD: begin
          if (cmd_done_i) begin
            if (cmd_ok_i) st <= ST_RD_T;
            else begin
              err_o <= 1'b1;
              st    <= ST_IDLE;
            end
          end
        end
        ST_RD_T: begin
          if (slot_done_i) begin
            rd_t <= slot_rbit_i;
            st   <= ST_RD_C;
          end
        end
        ST_RD_C: begin
          if (slot_done_i) begin
            if (pick.none) begin
              if (retry_over) begin
                err_o <= 1'b1;
                st    <= ST_IDLE;
              end
            end else begin
              dir_q <= pick.dir;
              if (pick.conflict && !pick.dir) begin
                last_idx <= bit_idx;
                last_vld <= 1'b1;
              end
              st <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (slot_done_i) begin
            cur_id[bit_idx] <= dir_q;
            if (ev_last_bit) st <= ST_EMIT;
            else begin
              bit_idx <= bit_idx + 1'b1;
              st      <= ST_RD_T;
            end
          end
        end
        ST_EMIT: begin
          prev_id   <= cur_id;
          prior_idx <= last_idx;
          prior_vld <= last_vld;
          if (!last_vld) begin
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else if (pass_full) begin
            err_o <= 1'b1;
            st    <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (ev_begin) begin
        st       <= ST_CMD;
        bit_idx  <= '0;
        last_vld <= 1'b0;
        cur_id   <= '0;
      end
    end
  end

  assign busy_o       = st != ST_IDLE;
  assign cmd_req_o    = st == ST_CMD;
  assign slot_req_o   = (st == ST_RD_T) || (st == ST_RD_C) || (st == ST_WR);
  assign slot_write_o = st == ST_WR;
  assign slot_wbit_o  = dir_q;
  assign id_valid_o   = ev_pass_end;
  assign id_value_o   = cur_id;
  assign id_family_o  = cur_id[7:0];
  assign id_crc_ok_o  = crc_zero;

  assert_cmd_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (cmd_req_o && !slot_req_o));

  assert_forced_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_decide && (rd_t ^ slot_rbit_i)) |=> (slot_write_o && slot_wbit_o == $past(rd_t)));

  assert_first_pass_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_decide && !rd_t && !slot_rbit_i && !prior_vld) |=> (slot_write_o && !slot_wbit_o));

  assert_noresp_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_noresp |=> (cmd_req_o || err_o));

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  assert_cmd_fail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_CMD) && cmd_done_i && !cmd_ok_i) |=> (err_o && !busy_o && !slot_req_o));

endmodule

// File: tb/test_owid_search.sv
module test_owid_search;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int MAXDEV     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cmd_done_i = 1'b0;
  logic cmd_ok_i = 1'b0;
  logic slot_done_i = 1'b0;
  logic slot_rbit_i = 1'b0;
  logic busy_o, cmd_req_o, slot_req_o, slot_write_o, slot_wbit_o;
  logic id_valid_o, id_crc_ok_o, done_o, err_o;
  logic [63:0] id_value_o;
  logic [7:0]  id_family_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  owid_search i_owid_search (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .cmd_req_o(cmd_req_o), .cmd_done_i(cmd_done_i), .cmd_ok_i(cmd_ok_i),
    .slot_req_o(slot_req_o), .slot_write_o(slot_write_o), .slot_wbit_o(slot_wbit_o),
    .slot_done_i(slot_done_i), .slot_rbit_i(slot_rbit_i),
    .id_valid_o(id_valid_o), .id_value_o(id_value_o), .id_family_o(id_family_o),
    .id_crc_ok_o(id_crc_ok_o), .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- device population model ----------------
  logic [63:0] dev_id [MAXDEV];
  bit          active [MAXDEV];
  int  ndev = 0;
  bit  bus_ok = 1'b1;
  int  inj_lim = 0;
  int  inj_bit = 10;
  int  inj_pass = 0;
  int  rd_cnt = 0, wr_cnt = 0, cmd_cnt = 0;
  bit  slot_before_cmd = 1'b0;

  function automatic logic [7:0] crc_bytes(input logic [63:0] v, input int nb);
    logic [7:0] c;
    c = 8'h00;
    for (int b = 0; b < nb; b++) begin
      c = c ^ v[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [63:0] make_id(input int seed, input bit bad);
    logic [63:0] h, r;
    logic [7:0]  c;
    h = 64'(seed + 1) * 64'h9E3779B97F4A7C15;
    r = '0;
    r[7:0]  = {4'h2, 4'(seed)};
    r[55:8] = h[59:12];
    c = crc_bytes(r, 7);
    if (bad) c = c ^ 8'h01;
    r[63:56] = c;
    return r;
  endfunction

  function automatic logic [63:0] rev64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63 - i];
    return r;
  endfunction

  // responder: command transactions and bit slots, driven at the falling edge
  initial begin
    int  bit_pos;
    bit  phase;
    bit  inj_now;
    bit  cmd_seen;
    logic v;
    bit_pos = 0; phase = 0; inj_now = 0; cmd_seen = 0;
    forever begin
      @(negedge clk);
      if (cmd_req_o && !cmd_done_i) begin
        cmd_done_i = 1'b1;
        cmd_ok_i   = bus_ok;
        cmd_cnt++;
        cmd_seen = 1;
        bit_pos = 0; phase = 0; inj_now = 0;
        for (int k = 0; k < MAXDEV; k++) active[k] = (k < ndev);
      end else begin
        cmd_done_i = 1'b0;
      end
      if (slot_req_o && !slot_done_i) begin
        if (!cmd_seen) slot_before_cmd = 1'b1;
        if (!slot_write_o) begin
          rd_cnt++;
          if (!phase) inj_now = (inj_pass < inj_lim) && (bit_pos == inj_bit);
          if (!phase && inj_now) inj_pass++;
          v = 1'b1;
          for (int k = 0; k < ndev; k++)
            if (active[k]) v = v & (phase ? ~dev_id[k][bit_pos] : dev_id[k][bit_pos]);
          slot_rbit_i = inj_now ? 1'b1 : v;
          phase = ~phase;
        end else begin
          wr_cnt++;
          for (int k = 0; k < ndev; k++)
            if (dev_id[k][bit_pos] != slot_wbit_o) active[k] = 0;
          bit_pos++;
          phase = 0;
        end
        slot_done_i = 1'b1;
      end else begin
        slot_done_i = 1'b0;
      end
      if (!busy_o) cmd_seen = 0;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [63:0] id;
    logic        ok;
  } exp_t;
  exp_t exp_q[$];

  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && id_valid_o) begin
        inj_pass = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected identifier", id_value_o, 64'h0);
        end else begin
          e = exp_q.pop_front();
          check(id_value_o == e.id, "R7", "identifier order/value (R2 R4)", id_value_o, e.id);
          check(id_family_o == e.id[7:0], "R7", "family byte", 64'(id_family_o), 64'(e.id[7:0]));
          check(id_crc_ok_o == e.ok, "R8", "crc ok flag", 64'(id_crc_ok_o), 64'(e.ok));
        end
      end
    end
  end

  // driver: builds a population, pushes expected identifiers, runs an enumeration
  task automatic run_case(input string tag, input int seed0, input int n, input int bad_idx,
                          input int lim, input bit ok, input bit exp_err, input int n_ids,
                          input bit late);
    logic [63:0] tmp [MAXDEV];
    logic [63:0] sw;
    bit got_done, got_err, id_seen;
    exp_t e;
    ndev = n;
    for (int k = 0; k < n; k++) begin
      dev_id[k] = make_id(seed0 + k, k == bad_idx);
      tmp[k] = dev_id[k];
    end
    for (int a = 0; a < n; a++)
      for (int b = a + 1; b < n; b++)
        if (rev64(tmp[b]) < rev64(tmp[a])) begin
          sw = tmp[a]; tmp[a] = tmp[b]; tmp[b] = sw;
        end
    for (int k = 0; k < n_ids; k++) begin
      e.id = tmp[k];
      e.ok = crc_bytes(tmp[k], 8) == 8'h00;
      exp_q.push_back(e);
    end
    inj_lim = lim; inj_pass = 0; bus_ok = ok;
    rd_cnt = 0; wr_cnt = 0; cmd_cnt = 0; slot_before_cmd = 0;
    got_done = 0; got_err = 0; id_seen = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && (cmd_req_o || cmd_done_i), "R1", {tag, " busy and command after start"},
          64'(busy_o), 64'h1);
    for (int cyc = 0; cyc < 40000 && !got_done && !got_err; cyc++) begin
      @(negedge clk);
      start_i = late && (cyc == 200 || cyc == 201);
      if (id_valid_o) id_seen = 1;
      if (done_o) got_done = 1;
      if (err_o) got_err = 1;
      if ((done_o || err_o) && busy_o)
        check(1'b0, "R9", {tag, " busy with outcome"}, 64'(busy_o), 64'h0);
    end
    start_i = 1'b0;
    check(got_err == exp_err && got_done == !exp_err, exp_err ? "R10" : "R9",
          {tag, " outcome err/done"}, {62'h0, got_err, got_done}, {62'h0, exp_err, !exp_err});
    check(exp_q.size() == 0, "R7", {tag, " all expected identifiers seen"},
          64'(exp_q.size()), 64'h0);
    check(!slot_before_cmd, "R1", {tag, " command precedes slots"}, 64'(slot_before_cmd), 64'h0);
    exp_q.delete();
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !err_o, "R9", {tag, " idle after outcome"},
          {61'h0, busy_o, done_o, err_o}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !cmd_req_o && !slot_req_o, "R1", "reset idle", 
          {61'h0, busy_o, cmd_req_o, slot_req_o}, 64'h0);
    check(!id_valid_o && !done_o && !err_o, "R1", "reset outputs",
          {61'h0, id_valid_o, done_o, err_o}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o, "R1", "idle after reset release", 64'(busy_o), 64'h0);

    // single device: one pass, slot counts
    run_case("R2 single", 3, 1, -1, 0, 1'b1, 1'b0, 1, 1'b0);
    check(rd_cnt == 128 && wr_cnt == 64, "R2", "slot counts one pass",
          {rd_cnt[31:0], wr_cnt[31:0]}, {32'd128, 32'd64});
    check(cmd_cnt == 1, "R1", "one command for one pass", 64'(cmd_cnt), 64'h1);

    // several devices: conflicts, forced bits, ordering
    run_case("R3 R4 five", 20, 5, -1, 0, 1'b1, 1'b0, 5, 1'b0);
    check(cmd_cnt == 5, "R4", "one pass per device", 64'(cmd_cnt), 64'd5);

    // bad CRC device
    run_case("R8 badcrc", 40, 3, 1, 0, 1'b1, 1'b0, 3, 1'b0);

    // five restarts every pass succeed
    run_case("R6 retries", 60, 3, -1, 5, 1'b1, 1'b0, 3, 1'b0);
    check(cmd_cnt == 18, "R6", "commands with five restarts per pass", 64'(cmd_cnt), 64'd18);

    // sixth consecutive no-response aborts
    run_case("R5 retry limit", 70, 3, -1, 6, 1'b1, 1'b1, 0, 1'b0);
    check(cmd_cnt == 6, "R5", "commands before abort", 64'(cmd_cnt), 64'd6);

    // failed command transaction
    run_case("R11 nopresence", 80, 2, -1, 0, 1'b0, 1'b1, 0, 1'b0);
    check(rd_cnt == 0 && wr_cnt == 0, "R11", "no slots after failed command",
          {rd_cnt[31:0], wr_cnt[31:0]}, 64'h0);

    // pass budget boundary
    run_case("R10 eleven", 100, 11, -1, 0, 1'b1, 1'b0, 11, 1'b0);
    run_case("R10 twelve", 100, 12, -1, 0, 1'b1, 1'b1, 11, 1'b0);
    check(cmd_cnt == 11, "R10", "passes before pass-limit abort", 64'(cmd_cnt), 64'd11);

    // start while busy is ignored
    run_case("R12 restart", 130, 4, -1, 0, 1'b1, 1'b0, 4, 1'b1);
    check(cmd_cnt == 4, "R12", "start during run adds no pass", 64'(cmd_cnt), 64'd4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule